// File: doc/BRIEF.md
# Open-Row Asynchronous DRAM Controller

This block turns a synchronous request port into the strobe sequence of an asynchronous DRAM whose address pins carry the row and the column at different times. A request carries a read/write flag, a row, a column and write data. It is handed over with a valid/ready handshake. For reads, the block returns the data word with a one-cycle valid pulse.

After an access the controller keeps the row open, with the row strobe held low. A later request to the same row needs only a column cycle. A request to any other row first releases the row strobe and waits out the precharge time. It then drives the new row onto the address pins, lowers the row strobe and waits the row-to-column delay before the column strobe falls. All delays are whole clock cycles set by parameters.

The row strobe may stay low only for a limited time. When an idle open row gets close to that limit, the controller closes the row itself. The next request is then handled as a miss.

Top module: `pgdram_ctrl`

## Requirements
- R1: During reset and right after it, the row strobe, column strobe and write enable are high, the data drive enable is low, `req_ready` is high and `rd_valid` is low.
- R2: A request accepted while no row is open, or while a different row is open, holds `dram_ras_n` high for T_RP cycles. It then holds `dram_ras_n` low with the zero-extended row on `dram_addr` for T_RCD cycles before the column strobe falls. `req_ready` returns T_RP+T_RCD+T_CAC+T_CP+1 cycles after acceptance.
- R3: A request accepted while its row is open keeps `dram_ras_n` low, lowers `dram_cas_n` in the very next cycle and returns `req_ready` T_CAC+T_CP+1 cycles after acceptance.
- R4: Each column access holds `dram_cas_n` low for exactly T_CAC cycles. During that time `dram_ras_n` is low and the zero-extended column is stable on `dram_addr`.
- R5: A read samples `dram_dq_in` at the clock edge that ends the T_CAC-th column-strobe-low cycle. It presents the word on `rd_data` with a one-cycle `rd_valid` pulse in the following cycle. Values on `dram_dq_in` at any other time have no effect.
- R6: A write drives `dram_we_n` low and `dram_dq_oe` high, with the request's data on `dram_dq_out`, exactly during the column-strobe-low cycles. A read keeps `dram_we_n` high and `dram_dq_oe` low throughout.
- R7: After every column access `dram_cas_n` stays high for T_CP cycles, with the row still open, before the next request can be accepted.
- R8: `req_ready` is low from the cycle after acceptance until the sequence ends. A request held valid in that time is not taken until `req_ready` is high again.
- R9: `dram_ras_n` never stays low for more than T_RAS_MAX consecutive cycles. If the controller is idle, the row is open and the row strobe has already been low for at least T_RAS_MAX-T_CAC-T_CP-2 cycles, then `req_ready` is low for one cycle, the row strobe rises in the next cycle and the next request is a miss.
- R10: While idle with a row open, `dram_ras_n` stays low and `dram_cas_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data toward the memory |
| dram_dq_oe | output | 1 | Enable for the data drivers |
| dram_dq_in | input | DATA_W | Data from the memory |

## Verification
If the open-row record is wrong, a request to the open row is classed as a miss, or the reverse. That shows at the ports in the cycle right after acceptance: the row strobe rises when it should stay low, or the column strobe falls with no activation before it. If the delay counter or the capture point is off by one cycle, the returned word is a placeholder pattern the memory model drives outside the valid window, and it appears on the `rd_valid` cycle. A wrong strobe-low run counter first shows as `req_ready` falling one cycle early or late on an idle open row.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_ACT  = 3'd2,
      ST_COL  = 3'd3,
      ST_CPH  = 3'd4
   } pg_state_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/pgdram_delay.sv
module pgdram_delay #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pgdram_rowtrack.sv
module pgdram_rowtrack #(
   parameter int ROW_W     = 8,
   parameter int T_RAS_MAX = 40,
   parameter int CLOSE_AT  = 35
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] probe_row,
   input  logic             set_row,
   input  logic [ROW_W-1:0] set_val,
   input  logic             drop_row,
   output logic             row_open,
   output logic             hit,
   output logic             close_due
);
   localparam int RUN_W = $clog2(T_RAS_MAX + 1);

   logic [ROW_W-1:0] open_row_q;
   logic             open_q;
   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q     <= 1'b0;
         open_row_q <= '0;
      end else if (set_row) begin
         open_q     <= 1'b1;
         open_row_q <= set_val;
      end else if (drop_row) begin
         open_q     <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       run_q <= '0;
      else if (!open_q)                 run_q <= '0;
      else if (run_q != {RUN_W{1'b1}})  run_q <= run_q + 1'b1;
   end

   assign row_open  = open_q;
   assign hit       = open_q && (probe_row == open_row_q);
   assign close_due = open_q && (run_q >= RUN_W'(CLOSE_AT));

   // R9
   ras_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> (run_q < RUN_W'(T_RAS_MAX)));

   // R2
   set_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_row && drop_row));

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq
   import pgdram_pkg::*;
#(
   parameter int T_RP  = 2,
   parameter int T_RCD = 2,
   parameter int T_CAC = 2,
   parameter int T_CP  = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_valid,
   input  logic      hit,
   input  logic      row_open,
   input  logic      close_due,
   input  logic      wr_q,
   output pg_state_e state,
   output logic      req_ready,
   output logic      accept,
   output logic      set_row,
   output logic      drop_row,
   output logic      cap
);
   localparam int TMAX = max4(T_RP, T_RCD, T_CAC, T_CP);
   localparam int CW   = $clog2(TMAX + 1);

   pg_state_e      state_q, state_d;
   logic           ld;
   logic [CW-1:0]  ld_val;
   logic           zero;

   pgdram_delay #(.W(CW)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .zero     (zero)
   );

   assign req_ready = (state_q == ST_IDLE) && !(row_open && close_due);
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d  = state_q;
      ld       = 1'b0;
      ld_val   = '0;
      set_row  = 1'b0;
      drop_row = 1'b0;
      cap      = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (row_open && close_due) begin
               drop_row = 1'b1;
            end else if (req_valid) begin
               ld = 1'b1;
               if (hit) begin
                  state_d = ST_COL;
                  ld_val  = CW'(T_CAC - 1);
               end else begin
                  state_d  = ST_PRE;
                  ld_val   = CW'(T_RP - 1);
                  drop_row = 1'b1;
               end
            end
         end
         ST_PRE: if (zero) begin
            state_d = ST_ACT;
            ld      = 1'b1;
            ld_val  = CW'(T_RCD - 1);
            set_row = 1'b1;
         end
         ST_ACT: if (zero) begin
            state_d = ST_COL;
            ld      = 1'b1;
            ld_val  = CW'(T_CAC - 1);
         end
         ST_COL: if (zero) begin
            state_d = ST_CPH;
            ld      = 1'b1;
            ld_val  = CW'(T_CP - 1);
            cap     = !wr_q;
         end
         ST_CPH: if (zero) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;

   // R3
   hit_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && hit) |=> (state_q == ST_COL));

   // R2
   miss_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !hit) |=> (state_q == ST_PRE));

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> !req_ready);

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
   import pgdram_pkg::*;
#(
   parameter int ROW_W     = 8,
   parameter int COL_W     = 8,
   parameter int DATA_W    = 16,
   parameter int T_RP      = 2,
   parameter int T_RCD     = 2,
   parameter int T_CAC     = 2,
   parameter int T_CP      = 1,
   parameter int T_RAS_MAX = 40,
   localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_wr,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [ADDR_W-1:0] dram_addr,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   localparam int CLOSE_AT = T_RAS_MAX - T_CAC - T_CP - 2;

   if (T_RP < 1 || T_RCD < 1 || T_CAC < 1 || T_CP < 1) begin : g_bad_delay
      $error("pgdram_ctrl: every delay parameter must be at least one cycle");
   end
   if (CLOSE_AT <= T_RCD + T_CAC + T_CP) begin : g_bad_rasmax
      $error("pgdram_ctrl: T_RAS_MAX too small for one activation and access");
   end
   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("pgdram_ctrl: widths must be positive");
   end

   pg_state_e         state;
   logic              accept, set_row, drop_row, cap;
   logic              row_open, hit, close_due;
   logic              wr_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [DATA_W-1:0] wdata_q;
   logic [ADDR_W-1:0] row_bus, col_bus;

   pgdram_rowtrack #(
      .ROW_W     (ROW_W),
      .T_RAS_MAX (T_RAS_MAX),
      .CLOSE_AT  (CLOSE_AT)
   ) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .probe_row (req_row),
      .set_row   (set_row),
      .set_val   (row_q),
      .drop_row  (drop_row),
      .row_open  (row_open),
      .hit       (hit),
      .close_due (close_due)
   );

   pgdram_seq #(
      .T_RP  (T_RP),
      .T_RCD (T_RCD),
      .T_CAC (T_CAC),
      .T_CP  (T_CP)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .hit       (hit),
      .row_open  (row_open),
      .close_due (close_due),
      .wr_q      (wr_q),
      .state     (state),
      .req_ready (req_ready),
      .accept    (accept),
      .set_row   (set_row),
      .drop_row  (drop_row),
      .cap       (cap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         row_q   <= '0;
         col_q   <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         wr_q    <= req_wr;
         row_q   <= req_row;
         col_q   <= req_col;
         wdata_q <= req_wdata;
      end
   end

   if (ROW_W < ADDR_W) begin : g_row_pad
      assign row_bus = {{(ADDR_W - ROW_W){1'b0}}, row_q};
   end else begin : g_row_full
      assign row_bus = row_q;
   end
   if (COL_W < ADDR_W) begin : g_col_pad
      assign col_bus = {{(ADDR_W - COL_W){1'b0}}, col_q};
   end else begin : g_col_full
      assign col_bus = col_q;
   end

   assign dram_ras_n  = !row_open;
   assign dram_cas_n  = (state != ST_COL);
   assign dram_addr   = (state == ST_COL) ? col_bus : row_bus;
   assign dram_we_n   = !((state == ST_COL) && wr_q);
   assign dram_dq_oe  = (state == ST_COL) && wr_q;
   assign dram_dq_out = wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cap;
         if (cap) rd_data <= dram_dq_in;
      end
   end

   // R4
   cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   // R4
   col_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

   // R6
   drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> (!dram_cas_n && !dram_we_n));

   // R5
   rd_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(state) == ST_COL));

   // R2
   pre_ras_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRE) |-> dram_ras_n);

   // R10
   idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && row_open) |-> (!dram_ras_n && dram_cas_n));

endmodule

// File: tb/sim_pgdram_ctrl.sv
module sim_pgdram_ctrl;
   localparam int ROW_W = 8, COL_W = 8, DATA_W = 16;
   localparam int T_RP = 2, T_RCD = 2, T_CAC = 2, T_CP = 1, T_RAS_MAX = 40;
   localparam int CLOSE_AT = T_RAS_MAX - T_CAC - T_CP - 2;
   localparam logic [15:0] JUNK = 16'hDEAD;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, req_valid, req_ready, req_wr, rd_valid;
   logic [7:0] req_row, req_col, dram_addr;
   logic [15:0] req_wdata, rd_data, dram_dq_out, dram_dq_in;
   logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;

   pgdram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RP(T_RP),
      .T_RCD(T_RCD), .T_CAC(T_CAC), .T_CP(T_CP), .T_RAS_MAX(T_RAS_MAX)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_wr(req_wr), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
      .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
      .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

   int pass_n = 0, fail_n = 0;
   int cyc = 0, acc_at = -1000, busy_until = -1, rd_at = -1, run = 0, clow = 0;
   bit acc_hit, acc_wr, exp_open = 0, prev_ras = 1;
   logic [7:0] acc_row, acc_col, exp_row, drow, dcol;
   logic [15:0] acc_wd, rd_exp;
   logic [15:0] shadow [int];
   logic [15:0] dmem [int];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      if (ok) pass_n++;
      else begin
         fail_n++;
         $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
      end
   endtask

   // cycle-by-cycle reference model and memory model
   always @(negedge clk) begin
      if (rst_n) begin
         int d, pre;
         bit close;
         cyc++;
         if (cyc <= busy_until) begin
            d   = cyc - acc_at;
            pre = acc_hit ? 0 : T_RP + T_RCD;
            chk(req_ready == 1'b0, "R8", "ready while busy", req_ready, 0);
            if (!acc_hit && d <= T_RP) begin
               chk(dram_ras_n == 1'b1, "R2", "ras in precharge", dram_ras_n, 1);
            end else if (d <= pre) begin
               chk(dram_ras_n == 1'b0, "R2", "ras in activate", dram_ras_n, 0);
               chk(dram_cas_n == 1'b1, "R2", "cas in activate", dram_cas_n, 1);
               chk(dram_addr == acc_row, "R2", "row addr", dram_addr, acc_row);
            end else if (d <= pre + T_CAC) begin
               chk(dram_ras_n == 1'b0, acc_hit ? "R3" : "R4", "ras in column", dram_ras_n, 0);
               chk(dram_cas_n == 1'b0, acc_hit ? "R3" : "R4", "cas in column", dram_cas_n, 0);
               chk(dram_addr == acc_col, "R4", "col addr", dram_addr, acc_col);
               chk(dram_we_n == !acc_wr, "R6", "we_n", dram_we_n, !acc_wr);
               chk(dram_dq_oe == acc_wr, "R6", "dq_oe", dram_dq_oe, acc_wr);
               if (acc_wr) chk(dram_dq_out == acc_wd, "R6", "write data", dram_dq_out, acc_wd);
            end else begin
               chk(dram_ras_n == 1'b0, "R7", "ras in cas-high", dram_ras_n, 0);
               chk(dram_cas_n == 1'b1, "R7", "cas-high time", dram_cas_n, 1);
               chk(dram_dq_oe == 1'b0, "R7", "dq_oe in cas-high", dram_dq_oe, 0);
            end
         end else begin
            close = exp_open && (run >= CLOSE_AT);
            chk(req_ready == !close, close ? "R9" : "R8", "idle ready", req_ready, !close);
            chk(dram_ras_n == !exp_open, "R10", "idle ras", dram_ras_n, !exp_open);
            chk(dram_cas_n == 1'b1, "R10", "idle cas", dram_cas_n, 1);
            chk(dram_dq_oe == 1'b0, "R6", "idle dq_oe", dram_dq_oe, 0);
            if (close) exp_open = 0;
            else if (req_valid) begin
               acc_hit = exp_open && (req_row == exp_row);
               acc_at  = cyc;
               acc_wr  = req_wr;
               acc_row = req_row;
               acc_col = req_col;
               acc_wd  = req_wdata;
               pre = acc_hit ? 0 : T_RP + T_RCD;
               busy_until = cyc + pre + T_CAC + T_CP;
               if (req_wr) shadow[{req_row, req_col}] = req_wdata;
               else begin
                  rd_at  = cyc + pre + T_CAC + 1;
                  rd_exp = shadow.exists({req_row, req_col}) ? shadow[{req_row, req_col}] : 16'h0;
               end
               exp_open = 1;
               exp_row  = req_row;
            end
         end
         chk(rd_valid == (cyc == rd_at), "R5", "rd_valid", rd_valid, cyc == rd_at);
         if (cyc == rd_at) chk(rd_data == rd_exp, "R5", "read data", rd_data, rd_exp);
         run = dram_ras_n ? 0 : run + 1;
         // memory model driven only from the pins
         if (prev_ras && !dram_ras_n) drow = dram_addr;
         if (!dram_cas_n) begin
            dcol = dram_addr;
            if (!dram_we_n && dram_dq_oe) dmem[{drow, dcol}] = dram_dq_out;
            if (clow == T_CAC - 1)
               dram_dq_in = dmem.exists({drow, dcol}) ? dmem[{drow, dcol}] : 16'h0;
            else
               dram_dq_in = JUNK;
            clow++;
         end else begin
            clow = 0;
            dram_dq_in = JUNK;
         end
         prev_ras = dram_ras_n;
      end
   end

   task automatic issue(input bit wr, input logic [7:0] row, input logic [7:0] col,
                        input logic [15:0] wd);
      @(posedge clk); #2;
      req_valid = 1'b1; req_wr = wr; req_row = row; req_col = col; req_wdata = wd;
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0;
      req_row = '0; req_col = '0; req_wdata = '0; dram_dq_in = JUNK;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(dram_ras_n == 1'b1, "R1", "reset ras", dram_ras_n, 1);
      chk(dram_cas_n == 1'b1, "R1", "reset cas", dram_cas_n, 1);
      chk(dram_we_n == 1'b1, "R1", "reset we", dram_we_n, 1);
      chk(dram_dq_oe == 1'b0, "R1", "reset oe", dram_dq_oe, 0);
      chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
      chk(rd_valid == 1'b0, "R1", "reset rd_valid", rd_valid, 0);
      @(posedge clk); #2; rst_n = 1'b1;
      // cold miss, then hits on the open row (R2, R3)
      issue(1, 8'd5, 8'd1, 16'hA1A1);
      issue(1, 8'd5, 8'd2, 16'hB2B2);
      issue(0, 8'd5, 8'd1, 16'h0);
      issue(0, 8'd5, 8'd2, 16'h0);
      issue(1, 8'd5, 8'd255, 16'h7E7E);
      // row change, unwritten location, return to first row (R2, R5)
      issue(0, 8'd9, 8'd0, 16'h0);
      issue(1, 8'd9, 8'd0, 16'h1234);
      issue(0, 8'd5, 8'd255, 16'h0);
      issue(0, 8'd9, 8'd0, 16'h0);
      // idle past the strobe-low budget: forced close, then a miss (R9)
      repeat (45) @(posedge clk);
      issue(0, 8'd9, 8'd0, 16'h0);
      // long run of hits crossing the budget mid-stream (R9, R3, R6)
      for (int i = 0; i < 12; i++)
         issue(i[0], 8'd5, 8'(i * 17), 16'h0100 + 16'(i));
      for (int i = 0; i < 4; i++)
         issue(0, 8'd5, 8'(i * 17), 16'h0);
      issue(0, 8'd255, 8'd0, 16'h0);
      issue(1, 8'd255, 8'd0, 16'hFFFF);
      issue(0, 8'd255, 8'd0, 16'h0);
      repeat (10) @(posedge clk);
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fail_n++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
      $finish;
   end

endmodule